// File: doc/BRIEF.md
# Paged Address Translator With Translation Cache

This block maps a logical address from a processor onto a physical address through a single-level page table kept in memory. The logical address has two fields. The upper bits select a page and the lower bits give the byte offset inside that page. The physical address joins a frame number with the same offset.

A small fully-associative translation cache is searched first. A hit answers on the next clock. A miss starts a walk. The block issues one read on its memory port, at the page-table base value plus the page number, and then waits for the entry to return. While it waits, `busy` is high. When the entry comes back, the response is produced and a valid entry is copied into the cache in round-robin order.

Every access is checked against the entry's valid bit and its 2-bit permission code. A failed check yields a fault instead of an address. Loading a new table base empties the cache, so translations from an old table are never reused.

Top module: `paged_xlate`

## Requirements
- R1: After reset, `resp_valid`, `busy` and `mem_rd_en` are low, and the translation cache holds no entries.
- R2: The page number is `req_vaddr[LA_W-1:OFF_W]` and the offset is `req_vaddr[OFF_W-1:0]`. A permitted access returns `resp_paddr = {frame, offset}`.
- R3: When an accepted request hits the cache, `resp_valid` is high in the cycle after acceptance, and no memory read is issued.
- R4: When an accepted request misses, `mem_rd_en` is high in the accepting cycle with `mem_rd_addr = ptbr + page` (modulo 2^MEM_AW). `busy` is then high until the cycle `mem_rd_valid` is seen, and the response follows one cycle after that.
- R5: A table entry is laid out as bit 0 = valid, bits [2:1] = permission and bits [PTE_W-1:3] = frame. An entry whose valid bit is 0 gives a fault and is not cached, so the next access to that page walks again.
- R6: Permission codes are 00 read-only, 01 read-write, 10 execute-only and 11 no access. Access kinds are 0 load, 1 store, 2 fetch and 3 load. A store to a read-only page faults. A load to an execute-only page faults. Every access to a code-11 page faults. A fault returns `resp_paddr = 0`.
- R7: The cache has TLB_ENTRIES slots. Each walk that returns a valid entry writes the next slot in round-robin order, whether or not that access faults.
- R8: A base-register write accepted while not busy empties the cache and sends the replacement pointer back to slot 0.
- R9: While `busy` is high, `req_valid` and `ptbr_we` are ignored.
- R10: A request in the same cycle as `ptbr_we` is ignored: it gives no response and no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr_we | input | 1 | Load the page-table base register |
| ptbr_wdata | input | MEM_AW | New page-table base |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | LA_W | Logical address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| busy | output | 1 | A table walk is in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | PA_W | Physical address, 0 on fault |
| resp_fault | output | 1 | The access was refused |
| mem_rd_en | output | 1 | Table-entry read request |
| mem_rd_addr | output | MEM_AW | Table-entry address |
| mem_rd_valid | input | 1 | Table-entry data is valid |
| mem_rd_data | input | PTE_W | Table entry |

## Verification
The hardest situation to create from the ports is a request or a base-register write that arrives while a walk is still waiting for memory. Both must leave the outstanding walk, the cache contents and the replacement order untouched. The stimulus handles this on every miss. During the wait it drives a second request to a different address and pulses a base-register write with a different value. Later hit/miss predictions and read addresses then show whether either one had any effect. A scattered address order over eight pages and four slots forces frequent evictions, so a wrong replacement order appears as an unexpected read or a missing one.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam logic [1:0] PERM_RO   = 2'b00;
  localparam logic [1:0] PERM_RW   = 2'b01;
  localparam logic [1:0] PERM_XO   = 2'b10;
  localparam logic [1:0] PERM_NONE = 2'b11;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  // Permission rule applied on hits and on walk results alike
  function automatic logic access_ok(input logic [1:0] perm, input logic [1:0] kind);
    case (perm)
      PERM_RO: access_ok = (kind != KIND_STORE);
      PERM_RW: access_ok = 1'b1;
      PERM_XO: access_ok = (kind == KIND_FETCH);
      default: access_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pgx_tlb.sv
module pgx_tlb #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 3,
  parameter int FRM_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               hit,
  output logic [FRM_W-1:0]   hit_frame,
  output logic [1:0]         hit_perm,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ENTRIES-1:0] valid_vec,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [FRM_W-1:0]   fill_frame,
  input  logic [1:0]         fill_perm
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0] e_vpn   [ENTRIES];
  logic [FRM_W-1:0] e_frame [ENTRIES];
  logic [1:0]       e_perm  [ENTRIES];
  logic [IDX_W-1:0] rr_ptr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec[g] = valid_vec[g] && (e_vpn[g] == lk_vpn);
  end

  always_comb begin
    hit_frame = '0;
    hit_perm  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit_frame = hit_frame | e_frame[i];
        hit_perm  = hit_perm  | e_perm[i];
      end
    end
  end
  assign hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid_vec <= '0;
      rr_ptr    <= '0;
    end else if (fill_en) begin
      valid_vec[rr_ptr] <= 1'b1;
      rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      e_vpn[rr_ptr]   <= fill_vpn;
      e_frame[rr_ptr] <= fill_frame;
      e_perm[rr_ptr]  <= fill_perm;
    end
  end
endmodule

// File: rtl/pgx_walker.sv
module pgx_walker #(
  parameter int VPN_W  = 3,
  parameter int OFF_W  = 2,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VPN_W-1:0]  start_vpn,
  input  logic [OFF_W-1:0]  start_off,
  input  logic [1:0]        start_kind,
  input  logic [MEM_AW-1:0] ptbr,
  input  logic              mem_rd_valid,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  output logic              done,
  output logic [VPN_W-1:0]  held_vpn,
  output logic [OFF_W-1:0]  held_off,
  output logic [1:0]        held_kind
);
  typedef enum logic {W_IDLE, W_WAIT} wstate_e;
  wstate_e st;

  function automatic logic [MEM_AW-1:0] pte_addr(input logic [MEM_AW-1:0] base,
                                                 input logic [VPN_W-1:0] vpn);
    pte_addr = base + MEM_AW'(vpn);
  endfunction

  assign busy        = (st == W_WAIT);
  assign mem_rd_en   = start && !busy;
  assign mem_rd_addr = pte_addr(ptbr, start_vpn);
  assign done        = busy && mem_rd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= W_IDLE;
      held_vpn  <= '0;
      held_off  <= '0;
      held_kind <= '0;
    end else if (mem_rd_en) begin
      st        <= W_WAIT;
      held_vpn  <= start_vpn;
      held_off  <= start_off;
      held_kind <= start_kind;
    end else if (done) begin
      st <= W_IDLE;
    end
  end
endmodule

// File: rtl/paged_xlate.sv
module paged_xlate
  import pgx_pkg::*;
#(
  parameter int LA_W        = 5,
  parameter int OFF_W       = 2,
  parameter int PA_W        = 5,
  parameter int MEM_AW      = 8,
  parameter int TLB_ENTRIES = 4,
  localparam int VPN_W      = LA_W - OFF_W,
  localparam int FRM_W      = PA_W - OFF_W,
  localparam int PTE_W      = FRM_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptbr_we,
  input  logic [MEM_AW-1:0] ptbr_wdata,
  input  logic              req_valid,
  input  logic [LA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  output logic              busy,
  output logic              resp_valid,
  output logic [PA_W-1:0]   resp_paddr,
  output logic              resp_fault,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [PTE_W-1:0]  mem_rd_data
);
  logic [MEM_AW-1:0] ptbr_q;
  logic [VPN_W-1:0]  lk_vpn;
  logic [OFF_W-1:0]  lk_off;

  // Named internal events, used by the bound checker
  logic req_accept, ptbr_wr, hit_acc, miss_acc, walk_done, fill_en;
  logic tlb_hit;
  logic [FRM_W-1:0] tlb_frame;
  logic [1:0]       tlb_perm;
  logic [TLB_ENTRIES-1:0] tlb_hit_vec, tlb_valid_vec;

  logic [VPN_W-1:0] w_vpn;
  logic [OFF_W-1:0] w_off;
  logic [1:0]       w_kind;

  logic             pte_v;
  logic [1:0]       pte_perm;
  logic [FRM_W-1:0] pte_frame;

  assign lk_vpn     = req_vaddr[LA_W-1:OFF_W];
  assign lk_off     = req_vaddr[OFF_W-1:0];
  assign ptbr_wr    = ptbr_we && !busy;
  assign req_accept = req_valid && !busy && !ptbr_we;
  assign hit_acc    = req_accept && tlb_hit;
  assign miss_acc   = req_accept && !tlb_hit;

  assign pte_v     = mem_rd_data[0];
  assign pte_perm  = mem_rd_data[2:1];
  assign pte_frame = mem_rd_data[PTE_W-1:3];
  assign fill_en   = walk_done && pte_v;

  always_ff @(posedge clk) begin
    if (!rst_n)       ptbr_q <= '0;
    else if (ptbr_wr) ptbr_q <= ptbr_wdata;
  end

  pgx_tlb #(.ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .FRM_W(FRM_W)) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(ptbr_wr), .lk_vpn(lk_vpn),
    .hit(tlb_hit), .hit_frame(tlb_frame), .hit_perm(tlb_perm),
    .hit_vec(tlb_hit_vec), .valid_vec(tlb_valid_vec),
    .fill_en(fill_en), .fill_vpn(w_vpn), .fill_frame(pte_frame), .fill_perm(pte_perm)
  );

  pgx_walker #(.VPN_W(VPN_W), .OFF_W(OFF_W), .MEM_AW(MEM_AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(miss_acc), .start_vpn(lk_vpn),
    .start_off(lk_off), .start_kind(req_kind), .ptbr(ptbr_q),
    .mem_rd_valid(mem_rd_valid), .busy(busy), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .done(walk_done), .held_vpn(w_vpn),
    .held_off(w_off), .held_kind(w_kind)
  );

  logic hit_ok, walk_ok;
  assign hit_ok  = access_ok(tlb_perm, req_kind);
  assign walk_ok = pte_v && access_ok(pte_perm, w_kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_paddr <= '0;
    end else begin
      resp_valid <= hit_acc || walk_done;
      if (hit_acc) begin
        resp_fault <= !hit_ok;
        resp_paddr <= hit_ok ? {tlb_frame, lk_off} : '0;
      end else if (walk_done) begin
        resp_fault <= !walk_ok;
        resp_paddr <= walk_ok ? {pte_frame, w_off} : '0;
      end
    end
  end
endmodule

// File: rtl/pgx_chk.sv
module pgx_chk #(
  parameter int PA_W    = 5,
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_accept,
  input logic               tlb_hit,
  input logic               mem_rd_en,
  input logic               busy,
  input logic               mem_rd_valid,
  input logic               resp_valid,
  input logic               resp_fault,
  input logic [PA_W-1:0]    resp_paddr,
  input logic               ptbr_wr,
  input logic [ENTRIES-1:0] tlb_valid_vec,
  input logic [ENTRIES-1:0] tlb_hit_vec
);
  p_hit_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept && tlb_hit |=> resp_valid && !busy);
  p_miss_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> busy && !resp_valid);
  p_walk_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_rd_valid |=> resp_valid && !busy);
  p_no_read_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_rd_en);
  p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> resp_paddr == '0);
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ptbr_wr |=> tlb_valid_vec == '0);
  p_unique_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tlb_hit_vec));
endmodule

bind paged_xlate pgx_chk #(.PA_W(PA_W), .ENTRIES(TLB_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_accept(req_accept), .tlb_hit(tlb_hit),
  .mem_rd_en(mem_rd_en), .busy(busy), .mem_rd_valid(mem_rd_valid),
  .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
  .ptbr_wr(ptbr_wr), .tlb_valid_vec(tlb_valid_vec), .tlb_hit_vec(tlb_hit_vec)
);

// File: tb/paged_xlate_tb.sv
module paged_xlate_tb;
  localparam int LA_W = 5, OFF_W = 2, PA_W = 5, MEM_AW = 8, NE = 4;
  localparam int PTE_W = PA_W - OFF_W + 3;

  logic clk = 0, rst_n = 0;
  logic ptbr_we = 0;
  logic [MEM_AW-1:0] ptbr_wdata = '0;
  logic req_valid = 0;
  logic [LA_W-1:0] req_vaddr = '0;
  logic [1:0] req_kind = '0;
  logic busy, resp_valid, resp_fault, mem_rd_en, mem_rd_valid = 0;
  logic [PA_W-1:0] resp_paddr;
  logic [MEM_AW-1:0] mem_rd_addr;
  logic [PTE_W-1:0] mem_rd_data = '0;

  always #2.5 clk = ~clk;

  paged_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .ptbr_we(ptbr_we), .ptbr_wdata(ptbr_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .busy(busy), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_fault(resp_fault), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  int n_chk = 0, n_bad = 0, n_walk = 0;
  bit finished = 0;

  // Bench-side reference state
  int m_vpn [NE];
  bit m_v   [NE];
  int m_ptr = 0;
  int cur_ptbr = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pte_at(input int a);
    int fr, pm, v;
    fr = (a * 3 + 1) % 8;
    pm = (a + (a >> 2)) % 4;
    v  = (a % 5 != 4) ? 1 : 0;
    return fr * 8 + pm * 2 + v;
  endfunction

  function automatic bit allowed(input int pm, input int kind);
    if (pm == 0) return kind != 1;
    if (pm == 1) return 1;
    if (pm == 2) return kind == 2;
    return 0;
  endfunction

  task automatic model_flush();
    for (int i = 0; i < NE; i++) m_v[i] = 0;
    m_ptr = 0;
  endtask

  task automatic set_ptbr(input int v);
    @(negedge clk);
    ptbr_we = 1; ptbr_wdata = MEM_AW'(v);
    @(posedge clk); #1;
    ptbr_we = 0;
    cur_ptbr = v; model_flush();
  endtask

  task automatic access(input int va, input int kind);
    int vpn, off, pte, addr, exp_pa, lat;
    bit hit, flt;
    vpn = va >> OFF_W; off = va % (1 << OFF_W);
    hit = 0;
    for (int i = 0; i < NE; i++) if (m_v[i] && m_vpn[i] == vpn) hit = 1;
    addr = (cur_ptbr + vpn) % (1 << MEM_AW);
    pte = pte_at(addr);
    flt = !((pte % 2 == 1) && allowed((pte >> 1) % 4, kind));
    exp_pa = flt ? 0 : ((pte >> 3) << OFF_W) + off;
    @(negedge clk);
    req_valid = 1; req_vaddr = LA_W'(va); req_kind = 2'(kind);
    #1;
    check(mem_rd_en == !hit, "R3/R7 hit prediction (read issued)", mem_rd_en, !hit);
    if (!hit) check(mem_rd_addr == addr, "R4 table address", mem_rd_addr, addr);
    @(posedge clk); #1;
    if (hit) begin
      req_valid = 0;
      check(resp_valid == 1 && busy == 0, "R3 hit response next cycle", resp_valid, 1);
    end else begin
      // R9: unrelated request and base write while the walk is outstanding
      req_vaddr = LA_W'(va ^ 5); req_kind = 2'(kind ^ 1);
      ptbr_we = 1; ptbr_wdata = MEM_AW'(cur_ptbr + 77);
      check(busy == 1 && resp_valid == 0, "R4 busy during walk", busy, 1);
      lat = 1 + (n_walk % 3); n_walk++;
      for (int k = 0; k < lat; k++) begin
        @(posedge clk); #1;
        ptbr_we = 0;
        check(busy == 1 && mem_rd_en == 0 && resp_valid == 0, "R9 busy ignores input", busy, 1);
      end
      mem_rd_valid = 1; mem_rd_data = PTE_W'(pte);
      @(posedge clk); #1;
      mem_rd_valid = 0; req_valid = 0;
      check(resp_valid == 1 && busy == 0, "R4 response after data", resp_valid, 1);
      if (pte % 2 == 1) begin
        m_vpn[m_ptr] = vpn; m_v[m_ptr] = 1; m_ptr = (m_ptr + 1) % NE;
      end
    end
    check(resp_fault == flt, (pte % 2 == 0) ? "R5 invalid entry fault" : "R6 permission fault",
          resp_fault, flt);
    check(resp_paddr == exp_pa, "R2 physical address", resp_paddr, exp_pa);
  endtask

  task automatic same_cycle_test(input int v);
    @(negedge clk);
    ptbr_we = 1; ptbr_wdata = MEM_AW'(v);
    req_valid = 1; req_vaddr = 5'd9; req_kind = 2'd0;
    #1;
    check(mem_rd_en == 0, "R10 no read with base write", mem_rd_en, 0);
    @(posedge clk); #1;
    ptbr_we = 0; req_valid = 0;
    check(resp_valid == 0 && busy == 0, "R10 request dropped", resp_valid, 0);
    cur_ptbr = v; model_flush();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_flush();
    repeat (3) @(posedge clk);
    #1;
    check(resp_valid == 0 && busy == 0 && mem_rd_en == 0, "R1 reset outputs", resp_valid, 0);
    @(negedge clk); rst_n = 1;
    // R1: empty cache after reset, so the first access must walk (ptbr 0)
    access(6, 0);
    set_ptbr(0);
    for (int p = 0; p < 3; p++) begin
      if (p == 1) same_cycle_test(10);
      if (p == 2) same_cycle_test(250);
      for (int j = 0; j < 96; j++) access((j * 13) % 32, j / 32);
      // R7 explicit eviction order: touch pages 0..4 then revisit page 0
      for (int q = 0; q < 5; q++) access(q * 4, 2);
      access(1, 2);
      // R8: flush then a page cached a moment ago must walk again
      set_ptbr(cur_ptbr);
      access(17, 0);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule